// File: doc/BRIEF.md
# Linked-List DMA Node Walker

This block walks a chain of nodes kept in memory and streams each node's payload to a device port, in the memory-to-device direction. Every node begins with a header word. The low 24 bits of the header point at the next node, and the top 8 bits give the number of payload words that follow the header. The walker reads the header, then reads the payload words at rising addresses and hands each one to the device. It reports the end of each node, then follows the pointer. It stops when the pointer is an end marker.

Two end-marker rules are available, and the choice is taken when the walk starts. The permissive rule treats any pointer with bit 23 set as the end. The exact rule accepts only the all-ones pointer. The current-node address is visible at all times, and after the walk it holds the raw marker value. Memory is reached through a simple request/response port with one read outstanding. The request is dropped for at least one cycle between nodes, so that other masters can use the bus.

Top module: `lldma_walker`

## Requirements
- R1: After reset, busy_o, mem_req_o, dev_valid_o, node_done_o and chain_done_o are 0 and cur_addr_o is 0.
- R2: A start_i pulse while idle reads the first header at start_addr_i with bits 1:0 forced to 0, and cur_addr_o takes that aligned address.
- R3: A header's bits 31:24 give the payload count N and bits 23:0 give the next pointer. The N payload words are read at node+4, node+8, … and are presented on the device port in that order.
- R4: A header with count 0 sends no payload, and node_done_o pulses for that node.
- R5: The next node is fetched at the pointer with bits 1:0 forced to 0, and every memory request address has bits 1:0 equal to 0.
- R6: With strict_end_i=0 at start, a pointer with bit 23 set ends the chain. With strict_end_i=1, only 24'hFFFFFF ends it, and any other pointer with bit 23 set is followed as a node.
- R7: While a node is in progress, cur_addr_o equals that node's aligned address. One cycle after chain_done_o, busy_o is 0 and cur_addr_o holds the unmodified end-marker pointer.
- R8: node_done_o pulses for one cycle after the last payload word of each node is accepted (or after the header, when the count is 0), and mem_req_o is 0 in that cycle. chain_done_o pulses together with the last node_done_o.
- R9: While dev_valid_o is 1 and dev_ready_i is 0, dev_data_o holds steady and no new memory read is issued.
- R10: A start_i pulse while busy_o is 1 is ignored, and the walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| start_addr_i | input | 24 | Address of the first node |
| strict_end_i | input | 1 | End-marker rule: 0 = bit 23 set, 1 = all ones |
| busy_o | output | 1 | Walk in progress |
| cur_addr_o | output | 24 | Current-node address; raw marker after the end |
| mem_req_o | output | 1 | Memory read request, held until the response |
| mem_addr_o | output | 24 | Memory read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| dev_valid_o | output | 1 | Payload word valid toward the device |
| dev_data_o | output | 32 | Payload word |
| dev_ready_i | input | 1 | Device accepts the word |
| node_done_o | output | 1 | One-cycle pulse at the end of each node |
| chain_done_o | output | 1 | One-cycle pulse when the end marker is reached |

## Verification
A stale pointer or count register shows at the ports within one node. The wrong header address appears on mem_addr_o at the next header read, and a miscounted payload shifts every later word in the device stream. A wrong end rule either stops the chain early or follows a marker into memory, which changes the count of node_done_o pulses and the final cur_addr_o a cycle after chain_done_o. Backpressure faults show as a changed dev_data_o in the same stalled cycle.

// File: rtl/lldma_pkg.sv
// Shared types for the linked-list walker.
// Assumes: nothing; holds only the sequencer state encoding.
package lldma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start pulse
        ST_HDR,    // reading the node header
        ST_PREQ,   // reading one payload word
        ST_POUT,   // offering the payload word to the device
        ST_NEND    // bus released, node closed, marker tested
    } walk_state_t;
endpackage

// File: rtl/lldma_end_detect.sv
// End-marker test on a next-node pointer.
// Assumes: the pointer is the raw header field; the rule is chosen by strict_i.
module lldma_end_detect #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] next_i,
    input  logic              strict_i,
    output logic              is_end_o
);
    logic legacy_hit;
    logic exact_hit;

    // Compute both rules and select one.
    always_comb begin
        legacy_hit = next_i[ADDR_W-1];
        exact_hit  = &next_i;
        is_end_o   = strict_i ? exact_hit : legacy_hit;
    end
endmodule

// File: rtl/lldma_payload_buf.sv
// One-word holding register between the memory response and the device port.
// Assumes: load_i only arrives while the buffer is empty.
module lldma_payload_buf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              dev_ready_i,
    output logic              dev_valid_o,
    output logic [DATA_W-1:0] dev_data_o,
    output logic              taken_o
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    // Fill on load, drain on a device handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
        end else if (valid_q && dev_ready_i) begin
            valid_q <= 1'b0;
        end
    end

    // Drive the device side and the handshake flag.
    always_comb begin
        dev_valid_o = valid_q;
        dev_data_o  = data_q;
        taken_o     = valid_q && dev_ready_i;
    end

    // R9: a stalled word stays put.
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid_o && !dev_ready_i) |=> (dev_valid_o && $stable(dev_data_o)));
endmodule

// File: rtl/lldma_seq.sv
// Node walking sequencer: header fetch, payload fetch, node close, marker stop.
// Assumes: one memory read outstanding; mem_rvalid_i only while mem_req_o is high.
module lldma_seq
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              strict_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              buf_taken_i,
    input  logic              is_end_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              buf_load_o,
    output logic [ADDR_W-1:0] next_o,
    output logic              strict_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              busy_o,
    output logic              node_done_o,
    output logic              chain_done_o
);
    localparam int BYTES      = DATA_W / 8;
    localparam int ALIGN_BITS = $clog2(BYTES);

    walk_state_t       state_q;
    logic [ADDR_W-1:0] node_q;
    logic [ADDR_W-1:0] word_q;
    logic [ADDR_W-1:0] next_q;
    logic [ADDR_W-1:0] cur_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              strict_q;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [ADDR_W-1:0] next_aligned;
    logic [ADDR_W-1:0] start_aligned;

    // Split the header and align the pointers.
    always_comb begin
        hdr_cnt       = mem_rdata_i[DATA_W-1 -: CNT_W];
        next_aligned  = {next_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        start_aligned = {start_addr_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end

    // Walk state, pointers and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            node_q   <= '0;
            word_q   <= '0;
            next_q   <= '0;
            cur_q    <= '0;
            cnt_q    <= '0;
            strict_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    node_q   <= start_aligned;
                    cur_q    <= start_aligned;
                    strict_q <= strict_i;
                    state_q  <= ST_HDR;
                end
                ST_HDR: if (mem_rvalid_i) begin
                    next_q  <= mem_rdata_i[ADDR_W-1:0];
                    cnt_q   <= hdr_cnt;
                    word_q  <= node_q + ADDR_W'(BYTES);
                    state_q <= (hdr_cnt == '0) ? ST_NEND : ST_PREQ;
                end
                ST_PREQ: if (mem_rvalid_i) begin
                    word_q  <= word_q + ADDR_W'(BYTES);
                    cnt_q   <= cnt_q - CNT_W'(1);
                    state_q <= ST_POUT;
                end
                ST_POUT: if (buf_taken_i) begin
                    state_q <= (cnt_q == '0) ? ST_NEND : ST_PREQ;
                end
                ST_NEND: begin
                    if (is_end_i) begin
                        cur_q   <= next_q;
                        state_q <= ST_IDLE;
                    end else begin
                        node_q  <= next_aligned;
                        cur_q   <= next_aligned;
                        state_q <= ST_HDR;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode outputs from the walk state.
    always_comb begin
        mem_req_o    = (state_q == ST_HDR) || (state_q == ST_PREQ);
        mem_addr_o   = (state_q == ST_HDR) ? node_q : word_q;
        buf_load_o   = (state_q == ST_PREQ) && mem_rvalid_i;
        next_o       = next_q;
        strict_o     = strict_q;
        cur_addr_o   = cur_q;
        busy_o       = (state_q != ST_IDLE);
        node_done_o  = (state_q == ST_NEND);
        chain_done_o = (state_q == ST_NEND) && is_end_i;
    end

    // R5: requests are word aligned.
    a_r5_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[ALIGN_BITS-1:0] == '0));

    // R4: an empty header closes its node on the next cycle.
    a_r4_empty_node: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && mem_rvalid_i && hdr_cnt == '0) |=> node_done_o);

    // R7: after the end the address holds a value that meets the chosen rule.
    a_r7_marker_kept: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |=> (!busy_o && (strict_q ? (&cur_addr_o) : cur_addr_o[ADDR_W-1])));

    // R10: a start while busy leaves the current address alone.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !node_done_o && start_i) |=> $stable(cur_addr_o));
endmodule

// File: rtl/lldma_walker.sv
// Top of the linked-list node walker: sequencer, end-marker test, payload buffer.
// Assumes: single-outstanding memory reads; the device may stall with dev_ready_i.
module lldma_walker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              strict_end_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              dev_valid_o,
    output logic [DATA_W-1:0] dev_data_o,
    input  logic              dev_ready_i,
    output logic              node_done_o,
    output logic              chain_done_o
);
    logic              buf_load;
    logic              buf_taken;
    logic              is_end;
    logic              strict_q;
    logic [ADDR_W-1:0] next_ptr;

    lldma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .strict_i     (strict_end_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .buf_taken_i  (buf_taken),
        .is_end_i     (is_end),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .buf_load_o   (buf_load),
        .next_o       (next_ptr),
        .strict_o     (strict_q),
        .cur_addr_o   (cur_addr_o),
        .busy_o       (busy_o),
        .node_done_o  (node_done_o),
        .chain_done_o (chain_done_o)
    );

    lldma_end_detect #(.ADDR_W(ADDR_W)) u_end (
        .next_i   (next_ptr),
        .strict_i (strict_q),
        .is_end_o (is_end)
    );

    lldma_payload_buf #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (buf_load),
        .data_i      (mem_rdata_i),
        .dev_ready_i (dev_ready_i),
        .dev_valid_o (dev_valid_o),
        .dev_data_o  (dev_data_o),
        .taken_o     (buf_taken)
    );

    // R8: the bus is free in the cycle a node closes.
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        node_done_o |-> !mem_req_o);

    // R9: no new read while a word waits for the device.
    a_r9_no_read_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid_o && !dev_ready_i) |-> !mem_req_o);
endmodule

// File: tb/lldma_walker_bench.sv
`timescale 1ns/1ps
module lldma_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        strict_end = 1'b0;
    logic        busy, mem_req, mem_rvalid, dev_valid, dev_ready;
    logic        node_done, chain_done;
    logic [23:0] cur_addr, mem_addr;
    logic [31:0] mem_rdata, dev_data;

    logic [31:0] mem [256];
    int          checks = 0, fails = 0, cycles = 0;
    logic        bp_en = 1'b0;

    // Monitor state
    logic [31:0] got_w [64];
    logic [23:0] got_n [32];
    int          nw, nn, rel_err, al_err, hold_err;
    logic        after_chain, chain_seen, fin_busy;
    logic [23:0] fin_addr;
    logic [31:0] prev_data;
    logic        prev_stall;

    // Expected
    logic [31:0] exp_w [64];
    logic [23:0] exp_n [32];
    int          ew, en;
    logic [23:0] exp_fin;

    always #2.5 clk = ~clk;

    lldma_walker u_lldma_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .strict_end_i(strict_end), .busy_o(busy), .cur_addr_o(cur_addr),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata), .dev_valid_o(dev_valid), .dev_data_o(dev_data),
        .dev_ready_i(dev_ready), .node_done_o(node_done), .chain_done_o(chain_done)
    );

    // Memory model: one response a cycle after each request.
    always @(posedge clk) begin
        if (!rst_n) mem_rvalid <= 1'b0;
        else        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata <= mem[mem_addr[9:2]];
    end

    // Device readiness: toggling under backpressure, else always ready.
    always @(posedge clk) dev_ready <= bp_en ? ~dev_ready : 1'b1;

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (prev_stall && dev_data != prev_data) hold_err = hold_err + 1;
        if (prev_stall && mem_req) hold_err = hold_err + 1;
        prev_stall = dev_valid && !dev_ready;
        prev_data  = dev_data;
        if (dev_valid && dev_ready && nw < 64) begin got_w[nw] = dev_data; nw = nw + 1; end
        if (node_done) begin
            if (nn < 32) got_n[nn] = cur_addr;
            nn = nn + 1;
            if (mem_req) rel_err = rel_err + 1;
        end
        if (mem_req && mem_addr[1:0] != 2'b00) al_err = al_err + 1;
        if (after_chain) begin
            fin_addr = cur_addr; fin_busy = busy; chain_seen = 1'b1; after_chain = 1'b0;
        end
        if (chain_done) after_chain = 1'b1;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference walk computed from the header layout and end rules.
    task automatic ref_walk(input logic [23:0] sa, input logic strict);
        logic [23:0] node = {sa[23:2], 2'b00};
        ew = 0; en = 0;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] h = mem[node[9:2]];
            logic [23:0] nx = h[23:0];
            logic        stop;
            exp_n[en] = node; en = en + 1;
            for (int i = 1; i <= int'(h[31:24]); i++) begin
                logic [23:0] a = node + 24'(4 * i);
                exp_w[ew] = mem[a[9:2]]; ew = ew + 1;
            end
            stop = strict ? (nx == 24'hFFFFFF) : nx[23];
            if (stop) begin exp_fin = nx; break; end
            node = {nx[23:2], 2'b00};
        end
    endtask

    task automatic run_chain(input string tag, input logic [23:0] sa, input logic strict,
                             input logic poke_busy);
        nw = 0; nn = 0; rel_err = 0; al_err = 0; hold_err = 0;
        after_chain = 0; chain_seen = 0;
        ref_walk(sa, strict);
        @(negedge clk);
        start = 1'b1; start_addr = sa; strict_end = strict;
        @(negedge clk);
        start = 1'b0;
        check(cur_addr == {sa[23:2], 2'b00}, "R2", {tag, " start address"}, 32'(cur_addr), 32'({sa[23:2], 2'b00}));
        if (poke_busy) begin
            repeat (6) @(negedge clk);
            start = 1'b1; start_addr = 24'h000200; strict_end = ~strict;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 2000 && !chain_seen; t++) @(negedge clk);
        check(chain_seen, "R8", {tag, " chain done seen"}, 32'(chain_seen), 32'd1);
        check(nw == ew, "R3", {tag, " payload count"}, 32'(nw), 32'(ew));
        for (int i = 0; i < ew && i < nw; i++)
            check(got_w[i] == exp_w[i], "R3", {tag, " payload word"}, got_w[i], exp_w[i]);
        check(nn == en, "R8", {tag, " node count"}, 32'(nn), 32'(en));
        for (int i = 0; i < en && i < nn; i++)
            check(got_n[i] == exp_n[i], "R7", {tag, " node address"}, 32'(got_n[i]), 32'(exp_n[i]));
        check(fin_addr == exp_fin, "R7", {tag, " final marker"}, 32'(fin_addr), 32'(exp_fin));
        check(!fin_busy, "R7", {tag, " idle after end"}, 32'(fin_busy), 32'd0);
        check(rel_err == 0, "R8", {tag, " bus released at node end"}, 32'(rel_err), 32'd0);
        check(al_err == 0, "R5", {tag, " aligned requests"}, 32'(al_err), 32'd0);
        check(hold_err == 0, "R9", {tag, " stall hold"}, 32'(hold_err), 32'd0);
        if (poke_busy)
            check(nn == en && fin_addr == exp_fin, "R10", {tag, " start while busy ignored"}, 32'(fin_addr), 32'(exp_fin));
    endtask

    task automatic t_reset;
        check(!busy && !mem_req && !dev_valid && !node_done && !chain_done, "R1",
              "reset controls", {27'd0, busy, mem_req, dev_valid, node_done, chain_done}, 32'd0);
        check(cur_addr == 24'd0, "R1", "reset address", 32'(cur_addr), 32'd0);
    endtask

    // R3/R4: three nodes, middle one empty, ended by all ones.
    task automatic t_basic;
        run_chain("basic", 24'h000100, 1'b0, 1'b0);
        check(nn == 3, "R4", "empty node still closes", 32'(nn), 32'd3);
    endtask

    // R6: the same pointer with bit 23 set ends in one rule and is followed in the other.
    task automatic t_end_rules;
        run_chain("legacy", 24'h000200, 1'b0, 1'b0);
        check(fin_addr == 24'h800040, "R6", "legacy stops at bit 23", 32'(fin_addr), 32'h800040);
        run_chain("strict", 24'h000200, 1'b1, 1'b0);
        check(nn == 2 && fin_addr == 24'hFFFFFF, "R6", "strict follows bit 23 pointer", 32'(fin_addr), 32'hFFFFFF);
    endtask

    // R5: unaligned start and unaligned next pointer.
    task automatic t_misaligned;
        run_chain("misaligned", 24'h000303, 1'b0, 1'b0);
        check(nn == 2 && got_n[1] == 24'h000340, "R5", "pointer aligned", 32'(got_n[1]), 32'h340);
    endtask

    // R9: device stalls every other cycle.
    task automatic t_backpressure;
        bp_en = 1'b1;
        run_chain("backpressure", 24'h000100, 1'b0, 1'b0);
        bp_en = 1'b0;
    endtask

    // R10: start pulse mid-walk.
    task automatic t_busy_start;
        run_chain("busy_start", 24'h000100, 1'b0, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
        mem[64] = {8'd2, 24'h000140};  mem[65] = 32'hA0000001; mem[66] = 32'hA0000002;
        mem[80] = {8'd0, 24'h000180};
        mem[96] = {8'd3, 24'hFFFFFF};  mem[97] = 32'hB0000001; mem[98] = 32'hB0000002; mem[99] = 32'hB0000003;
        mem[128] = {8'd1, 24'h800040}; mem[129] = 32'hD0000001;
        mem[16] = {8'd2, 24'hFFFFFF};  mem[17] = 32'hE0000001; mem[18] = 32'hE0000002;
        mem[192] = {8'd1, 24'h000343}; mem[193] = 32'hF0000001;
        mem[208] = {8'd0, 24'hFFFFFF};
        prev_stall = 1'b0; prev_data = '0;
        nw = 0; nn = 0; rel_err = 0; al_err = 0; hold_err = 0;
        after_chain = 0; chain_seen = 0; fin_busy = 0; fin_addr = '0;
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_basic;
        t_end_rules;
        t_misaligned;
        t_backpressure;
        t_busy_start;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule